// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack-Full Gating

This block arbitrates interrupts for a small microcontroller core. It has three sources: a time-base overflow and two timer overflows. Each source has a request flag and an enable bit. A single global enable gates all three. Software sees this state through two byte-wide registers. A request flag can be set by a one-cycle overflow event from its source, or by software writing the flag register.

The core asserts `coreReady` at an instruction boundary. In that cycle the controller checks four conditions: the global enable is set, at least one source has both its flag and its enable set, the return stack is not full, and the core is ready. When all four hold, the controller asserts a one-cycle acknowledge. In the same cycle it asks the core to push the program counter and presents the vector of the highest-priority pending source. The acknowledge also clears the winning flag and the global enable, so a second interrupt cannot nest unless the service routine sets the global enable again. A return strobe from the core pops the saved program counter and sets the global enable again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all flags, enables and the global enable are zero, both registers read 0x00, and `ackPulse`, `pushPc` and `popPc` are low.
- R2: A one-cycle pulse on a source's tick input sets that source's flag at the next clock edge. Flag bits in the flag register (`regSel`=1) are bit 0 time base, bit 1 timer 0 and bit 2 timer 1.
- R3: A write to the flag register loads flag bits 0..2 from the write data. If a tick arrives in the same cycle, the tick wins and the flag ends up set.
- R4: `ackPulse` is high in a cycle only if four conditions hold: the global enable is set, `coreReady` is high, `stackFull` is low, and some source has both its flag and its enable set. The control register (`regSel`=0) holds the global enable in bit 0 and the time base, timer 0 and timer 1 enables in bits 1, 2 and 3.
- R5: When several requests are pending, priority is time base, then timer 0, then timer 1. `vectorAddr` is 0x004, 0x008 or 0x00C for the winning source while `ackPulse` is high, and 0x000 otherwise.
- R6: `pushPc` equals `ackPulse`. The acknowledge clears the winning flag (unless a tick of that source coincides) and the global enable at the same clock edge, so it lasts a single cycle.
- R7: Requests that arrive while the global enable is clear still set their flags, and those flags stay set until the request is serviced or software clears them.
- R8: While `stackFull` is high, no request is acknowledged. Acknowledge resumes in the first cycle in which `stackFull` is low.
- R9: `popPc` follows `retStrobe`. A return strobe sets the global enable at the next edge. A software write to the global enable in the same cycle does not override the return strobe, and an acknowledge in the same cycle does.
- R10: If software sets the global enable during a service routine, a pending enabled request is acknowledged in the next ready cycle.
- R11: Unused register bits read as zero, and the enable bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickTimeBase | input | 1 | Time-base overflow event (one cycle) |
| tickTimer0 | input | 1 | Timer 0 overflow event |
| tickTimer1 | input | 1 | Timer 1 overflow event |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 flags |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register |
| coreReady | input | 1 | Core is at a point where it can take an interrupt |
| stackFull | input | 1 | Return stack is full |
| retStrobe | input | 1 | Return-from-interrupt executed |
| ackPulse | output | 1 | Interrupt acknowledged this cycle |
| pushPc | output | 1 | Push the program counter |
| popPc | output | 1 | Pop the saved program counter |
| vectorAddr | output | 12 | Vector address of the acknowledged source |

## Verification
The embedded assertions check the following on every cycle:
- the grant is one-hot and obeys the priority order;
- no acknowledge occurs without the global enable or while the stack is full;
- a tick always leaves its flag set;
- an acknowledge clears the global enable and the winning flag, and is never followed by a second acknowledge;
- a return strobe sets the global enable again.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model:
- the actual vector values;
- the read-back layout of both registers;
- the tick-beats-write rule;
- pending requests surviving a blocked interval;
- service resuming once the stack drains;
- nesting after a software re-enable.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_FLAG = 1'b1
  } regSel_e;

  // strobes sent by the selection logic to the register datapath
  typedef struct packed {
    logic               ack;
    logic [NUM_SRC-1:0] grant;
    logic               ret;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  ctrlStrobe_t        strobe,
  output logic               globalEn,
  output logic [NUM_SRC-1:0] srcEnable,
  output logic [NUM_SRC-1:0] srcFlag
);
  localparam int CTRL_USED = NUM_SRC + 1;

  logic               globalEnNext;
  logic [NUM_SRC-1:0] srcEnableNext;
  logic [NUM_SRC-1:0] srcFlagNext;
  logic               wrCtrl;
  logic               wrFlag;
  logic               unusedWrBits;

  assign wrCtrl       = regWrEn && (regSel == REG_CTRL);
  assign wrFlag       = regWrEn && (regSel == REG_FLAG);
  assign unusedWrBits = ^regWrData[DATA_W-1:CTRL_USED];

  always_comb begin
    if (strobe.ack)      globalEnNext = 1'b0;
    else if (strobe.ret) globalEnNext = 1'b1;
    else if (wrCtrl)     globalEnNext = regWrData[0];
    else                 globalEnNext = globalEn;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      always_comb begin
        if (srcTick[gi])                          srcFlagNext[gi] = 1'b1;
        else if (strobe.ack && strobe.grant[gi])  srcFlagNext[gi] = 1'b0;
        else if (wrFlag)                          srcFlagNext[gi] = regWrData[gi];
        else                                      srcFlagNext[gi] = srcFlag[gi];
      end
      assign srcEnableNext[gi] = wrCtrl ? regWrData[gi+1] : srcEnable[gi];

      assert_tick_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
        srcTick[gi] |=> srcFlag[gi]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      srcEnable <= '0;
      srcFlag   <= '0;
    end else begin
      globalEn  <= globalEnNext;
      srcEnable <= srcEnableNext;
      srcFlag   <= srcFlagNext;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel == REG_CTRL) regRdData[CTRL_USED-1:0] = {srcEnable, globalEn};
    else                    regRdData[NUM_SRC-1:0]   = srcFlag;
  end

  assert_ack_clears_ge_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ack |=> !globalEn);
  assert_ack_clears_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ack && ((strobe.grant & srcTick) == '0)) |=> ((srcFlag & $past(strobe.grant)) == '0));
  assert_ret_sets_ge_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ret && !strobe.ack) |=> globalEn);
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic               coreReady,
  input  logic               stackFull,
  input  logic               retReq,
  output ctrlStrobe_t        strobe,
  output logic [ADDR_W-1:0]  vectorAddr
);
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] firstPending;
  logic               anyPending;
  logic               mayTake;

  assign pending = srcFlag & srcEnable;

  // lowest index has the highest priority
  always_comb begin
    firstPending = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) firstPending = NUM_SRC'(1) << i;
    end
  end

  assign anyPending = |pending;
  assign mayTake    = globalEn && coreReady && !stackFull && anyPending;

  assign strobe.ack   = mayTake;
  assign strobe.grant = mayTake ? firstPending : '0;
  assign strobe.ret   = retReq;

  always_comb begin
    vectorAddr = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.grant[i]) vectorAddr = ADDR_W'(VEC_BASE + i * VEC_STRIDE);
    end
  end

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.grant));
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ack |=> !strobe.ack);
  assert_no_ack_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |-> !strobe.ack);
  assert_no_ack_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !strobe.ack);

  genvar gp;
  generate
    for (gp = 1; gp < NUM_SRC; gp++) begin : g_prio
      assert_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
        strobe.grant[gp] |-> (pending[gp-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 12,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickTimeBase,
  input  logic              tickTimer0,
  input  logic              tickTimer1,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              coreReady,
  input  logic              stackFull,
  input  logic              retStrobe,
  output logic              ackPulse,
  output logic              pushPc,
  output logic              popPc,
  output logic [ADDR_W-1:0] vectorAddr
);
  ctrlStrobe_t        strobe;
  logic               globalEn;
  logic [NUM_SRC-1:0] srcEnable;
  logic [NUM_SRC-1:0] srcFlag;
  logic [NUM_SRC-1:0] srcTick;

  assign srcTick = {tickTimer1, tickTimer0, tickTimeBase};

  irq_vec_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .srcTick   (srcTick),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .globalEn  (globalEn),
    .srcEnable (srcEnable),
    .srcFlag   (srcFlag)
  );

  irq_vec_sel #(
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_sel (
    .clk        (clk),
    .rstN       (rstN),
    .globalEn   (globalEn),
    .srcEnable  (srcEnable),
    .srcFlag    (srcFlag),
    .coreReady  (coreReady),
    .stackFull  (stackFull),
    .retReq     (retStrobe),
    .strobe     (strobe),
    .vectorAddr (vectorAddr)
  );

  assign ackPulse = strobe.ack;
  assign pushPc   = strobe.ack;
  assign popPc    = strobe.ret;
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickTimeBase = 1'b0, tickTimer0 = 1'b0, tickTimer1 = 1'b0;
  logic       regWrEn = 1'b0, regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       coreReady = 1'b0, stackFull = 1'b0, retStrobe = 1'b0;
  logic       ackPulse, pushPc, popPc;
  logic [11:0] vectorAddr;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string curReq = "R1";

  // behavioural model state
  bit       mGe = 0;
  bit [2:0] mEn = '0;
  bit [2:0] mFlag = '0;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rstN(rstN),
    .tickTimeBase(tickTimeBase), .tickTimer0(tickTimer0), .tickTimer1(tickTimer1),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .coreReady(coreReady), .stackFull(stackFull), .retStrobe(retStrobe),
    .ackPulse(ackPulse), .pushPc(pushPc), .popPc(popPc), .vectorAddr(vectorAddr)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] tk, input logic wr, input logic sel,
                      input logic [7:0] wd, input logic rdy, input logic full,
                      input logic rt);
    bit       eAck;
    int       win;
    int       eVec;
    int       eRd;
    bit       nGe;
    bit [2:0] nEn;
    bit [2:0] nFlag;
    @(negedge clk);
    {tickTimer1, tickTimer0, tickTimeBase} = tk;
    regWrEn = wr; regSel = sel; regWrData = wd;
    coreReady = rdy; stackFull = full; retStrobe = rt;
    #2;
    eAck = mGe && rdy && !full && ((mFlag & mEn) != 0);
    win = -1;
    for (int i = 2; i >= 0; i--) if (mFlag[i] && mEn[i]) win = i;
    eVec = eAck ? 4 + 4 * win : 0;
    eRd = sel ? int'(mFlag) : int'({mEn, mGe});
    chk("ackPulse", ackPulse, eAck);
    chk("pushPc", pushPc, eAck);
    chk("popPc", popPc, rt);
    chk("vectorAddr", vectorAddr, eVec);
    chk("regRdData", regRdData, eRd);
    nEn = (wr && !sel) ? wd[3:1] : mEn;
    if (eAck) nGe = 0;
    else if (rt) nGe = 1;
    else if (wr && !sel) nGe = wd[0];
    else nGe = mGe;
    for (int i = 0; i < 3; i++) begin
      if (tk[i]) nFlag[i] = 1;
      else if (eAck && i == win) nFlag[i] = 0;
      else if (wr && sel) nFlag[i] = wd[i];
      else nFlag[i] = mFlag[i];
    end
    @(posedge clk);
    #1;
    mGe = nGe; mEn = nEn; mFlag = nFlag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curReq = "R1";
    step(3'b000, 0, 0, 8'h00, 1, 0, 0);
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    curReq = "R11";
    step(3'b000, 1, 0, 8'hFE, 0, 0, 0);
    step(3'b000, 0, 0, 8'h00, 0, 0, 0);
    curReq = "R2";
    step(3'b010, 0, 1, 8'h00, 0, 0, 0);
    step(3'b000, 0, 1, 8'h00, 0, 0, 0);
    curReq = "R3";
    step(3'b001, 1, 1, 8'h00, 0, 0, 0);
    step(3'b000, 0, 1, 8'h00, 0, 0, 0);
    step(3'b000, 1, 1, 8'h00, 0, 0, 0);
    step(3'b000, 1, 1, 8'h06, 0, 0, 0);
    step(3'b000, 0, 1, 8'h00, 0, 0, 0);
    curReq = "R7";
    step(3'b111, 0, 1, 8'h00, 1, 0, 0);
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    curReq = "R4";
    step(3'b000, 1, 0, 8'h0F, 0, 0, 0);
    step(3'b000, 0, 0, 8'h00, 0, 0, 0);
    curReq = "R5";
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    curReq = "R6";
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    curReq = "R8";
    step(3'b000, 0, 0, 8'h00, 1, 1, 1);
    step(3'b000, 0, 0, 8'h00, 1, 1, 0);
    step(3'b000, 0, 1, 8'h00, 1, 1, 0);
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    curReq = "R9";
    step(3'b000, 1, 0, 8'h0E, 0, 0, 1);
    step(3'b000, 0, 0, 8'h00, 0, 0, 0);
    curReq = "R5";
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    curReq = "R10";
    step(3'b001, 0, 1, 8'h00, 1, 0, 0);
    step(3'b000, 1, 0, 8'h0F, 1, 0, 0);
    step(3'b000, 0, 1, 8'h00, 1, 0, 0);
    step(3'b000, 0, 0, 8'h00, 1, 0, 0);
    curReq = "RND";
    for (int n = 0; n < 600; n++) begin
      step(3'($urandom_range(0, 7) & $urandom_range(0, 7)),
           ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 6) == 0));
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule